// File: doc/BRIEF.md
# Scalar Double-Precision Category Tester

This block takes one 64-bit IEEE-754 binary64 operand and an 8-bit category selector. It reports, as a single bit, whether the operand falls into any of the selected special categories. The categories are quiet NaN, signaling NaN, positive and negative zero, positive and negative infinity, denormal, and finite negative.

The bit can be zeroed by a write-mask bit when masking is enabled. It is placed in bit 0 of a 64-bit mask result, and every other bit of that result is zero. A 4-bit reserved field must carry all ones. Any other value marks the request as an illegal encoding, and the held mask result is left untouched. The classification raises no floating-point exception flags.

Requests enter through a valid/ready handshake. The result sits in one output register stage that holds until it is taken. A two-state controller governs that stage:
- `ST_EMPTY` means no result is held.
- `ST_FULL` means a result is presented.

The controller moves as follows:
- `ST_EMPTY` goes to `ST_FULL` on an accepted request (*load*).
- `ST_FULL` stays in `ST_FULL` when the result is taken and a new request is accepted in the same cycle (*reload*).
- `ST_FULL` stays in `ST_FULL` when the result is not taken (*stall*).
- `ST_FULL` goes to `ST_EMPTY` when the result is taken and nothing new arrives (*drain*).

Top module: `fp64_class_test`

## Requirements
- R1: The operand is decoded as binary64, with sign in bit 63, exponent in bits 62:52 and fraction in bits 51:0. The categories are:
  - Infinity: exponent all ones and fraction zero.
  - Quiet NaN: exponent all ones and fraction bit 51 set.
  - Signaling NaN: exponent all ones, fraction bit 51 clear and fraction bits 50:0 nonzero.
  - Zero: exponent zero and fraction zero, with its sign taken from bit 63.
  - Denormal: exponent zero and fraction nonzero.
  - Finite negative: bit 63 set and exponent not all ones, which includes -0 and negative denormals.
- R2: The select bits map to categories as follows: bit0 quiet NaN, bit1 +0, bit2 -0, bit3 +infinity, bit4 -infinity, bit5 denormal, bit6 finite negative, bit7 signaling NaN. The result bit is the OR of the categories whose select bit is set.
- R3: With a select byte of zero, the result bit is 0 for every operand.
- R4: When masking is enabled and the write-mask bit is 0, result bit 0 is forced to 0. When masking is disabled, or the write-mask bit is 1, the classification result passes through.
- R5: Result bits 63:1 are always 0.
- R6: A request whose reserved field is not 4'b1111 sets the illegal flag with its result. The mask result keeps the value it held before that request.
- R7: A request whose reserved field equals 4'b1111 clears the illegal flag and updates the mask result.
- R8: The result appears with out_valid in the cycle after the request is accepted. While out_valid is high and out_ready is low, out_valid, out_mask and out_illegal stay unchanged.
- R9: in_ready is high when no result is held or when the held result is being taken in the same cycle.
- R10: After reset, out_valid is 0, out_mask is 0 and out_illegal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_value | input | 64 | Binary64 operand |
| in_sel | input | 8 | Category select byte |
| in_mask_en | input | 1 | Enable write-masking |
| in_kbit | input | 1 | Write-mask bit 0 |
| in_resv | input | 4 | Reserved field, must be 4'b1111 |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_mask | output | 64 | Mask result |
| out_illegal | output | 1 | Illegal encoding flag for the held result |

## Verification
The two functions that can share a cycle are the hand-off of a held result and the capture of a new request, which is the reload transition. The bench provokes this by presenting requests on consecutive cycles with out_ready high. It checks that each result appears exactly one cycle after its request, and that no result is lost or duplicated. A second overlap puts an illegal request directly behind a legal one. The bench then judges whether the mask register still shows the earlier legal result while the illegal flag rises.

// File: rtl/fp64_class_pkg.sv
package fp64_class_pkg;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int OPND_W = 1 + EXP_W + FRAC_W;
    localparam int CAT_N  = 8;
    localparam int RESV_W = 4;

    // category positions inside the select byte
    localparam int CAT_QNAN = 0;
    localparam int CAT_PZER = 1;
    localparam int CAT_NZER = 2;
    localparam int CAT_PINF = 3;
    localparam int CAT_NINF = 4;
    localparam int CAT_DENM = 5;
    localparam int CAT_FNEG = 6;
    localparam int CAT_SNAN = 7;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;
endpackage

// File: rtl/fp64_class_decode.sv
module fp64_class_decode
    import fp64_class_pkg::*;
(
    input  logic [OPND_W-1:0] value,
    output logic [CAT_N-1:0]  cat_hit
);
    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones, exp_zero, frac_zero;

    always_comb begin
        sgn       = value[OPND_W-1];
        expo      = value[OPND_W-2 -: EXP_W];
        frac      = value[FRAC_W-1:0];
        exp_ones  = &expo;
        exp_zero  = ~|expo;
        frac_zero = ~|frac;

        cat_hit           = '0;
        cat_hit[CAT_QNAN] = exp_ones & frac[FRAC_W-1];
        cat_hit[CAT_SNAN] = exp_ones & ~frac[FRAC_W-1] & (|frac[FRAC_W-2:0]);
        cat_hit[CAT_PZER] = exp_zero & frac_zero & ~sgn;
        cat_hit[CAT_NZER] = exp_zero & frac_zero & sgn;
        cat_hit[CAT_PINF] = exp_ones & frac_zero & ~sgn;
        cat_hit[CAT_NINF] = exp_ones & frac_zero & sgn;
        cat_hit[CAT_DENM] = exp_zero & ~frac_zero;
        cat_hit[CAT_FNEG] = sgn & ~exp_ones;
    end
endmodule

// File: rtl/fp64_class_merge.sv
module fp64_class_merge
    import fp64_class_pkg::*;
(
    input  logic [CAT_N-1:0] cat_hit,
    input  logic [CAT_N-1:0] sel,
    input  logic             mask_en,
    input  logic             kbit,
    output logic             result
);
    logic [CAT_N-1:0] gated;

    for (genvar g = 0; g < CAT_N; g++) begin : g_gate
        assign gated[g] = cat_hit[g] & sel[g];
    end

    // zeroing-only write-mask
    assign result = (|gated) & (~mask_en | kbit);
endmodule

// File: rtl/fp64_class_test.sv
module fp64_class_test
    import fp64_class_pkg::*;
#(
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [63:0]       in_value,
    input  logic [7:0]        in_sel,
    input  logic              in_mask_en,
    input  logic              in_kbit,
    input  logic [3:0]        in_resv,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [MASK_W-1:0] out_mask,
    output logic              out_illegal
);
    localparam logic [RESV_W-1:0] RESV_OK = '1;

    stage_state_t state_q, state_d;
    logic [CAT_N-1:0] cat_hit;
    logic             bit_res;
    logic             accept;
    logic             legal;
    logic             res_q;
    logic             ill_q;

    fp64_class_decode u_decode (
        .value   (in_value),
        .cat_hit (cat_hit)
    );

    fp64_class_merge u_merge (
        .cat_hit (cat_hit),
        .sel     (in_sel),
        .mask_en (in_mask_en),
        .kbit    (in_kbit),
        .result  (bit_res)
    );

    assign legal  = (in_resv == RESV_OK);
    assign accept = in_valid & in_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;                   // load
            ST_FULL:  if (out_ready && !accept) state_d = ST_EMPTY;    // drain
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= 1'b0;
            ill_q <= 1'b0;
        end else if (accept) begin
            ill_q <= ~legal;
            if (legal) res_q <= bit_res;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                out_valid = 1'b0;
                in_ready  = 1'b1;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
            end
            default: ;
        endcase
        out_mask    = {{(MASK_W-1){1'b0}}, res_q};
        out_illegal = ill_q;
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) && $stable(out_illegal)));

    // R8
    load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R6
    illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !legal) |=> (out_illegal && $stable(out_mask)));

    // R3
    zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && legal && in_sel == 8'h00) |=> !out_mask[0]);

    // R4
    zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && legal && in_mask_en && !in_kbit) |=> !out_mask[0]);

    // R5
    upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask[MASK_W-1:1] == '0);
endmodule

// File: tb/test_fp64_class_test.sv
`timescale 1ns/1ps
module test_fp64_class_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_value = '0;
    logic [7:0]  in_sel = '0;
    logic        in_mask_en = 1'b0;
    logic        in_kbit = 1'b0;
    logic [3:0]  in_resv = 4'hF;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_mask;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] m_mask = '0;
    logic        m_ill  = 1'b0;

    always #2 clk = ~clk;

    fp64_class_test i_fp64_class_test (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_value(in_value), .in_sel(in_sel), .in_mask_en(in_mask_en),
        .in_kbit(in_kbit), .in_resv(in_resv), .out_valid(out_valid),
        .out_ready(out_ready), .out_mask(out_mask), .out_illegal(out_illegal)
    );

    function automatic logic [7:0] ref_cats(input logic [63:0] v);
        logic s = v[63];
        logic [10:0] e = v[62:52];
        logic [51:0] f = v[51:0];
        logic [7:0] c = '0;
        c[0] = (e == 11'h7FF) && f[51];
        c[7] = (e == 11'h7FF) && !f[51] && (f[50:0] != 0);
        c[1] = (e == 0) && (f == 0) && !s;
        c[2] = (e == 0) && (f == 0) && s;
        c[3] = (e == 11'h7FF) && (f == 0) && !s;
        c[4] = (e == 11'h7FF) && (f == 0) && s;
        c[5] = (e == 0) && (f != 0);
        c[6] = s && (e != 11'h7FF);
        return c;
    endfunction

    function automatic logic ref_bit(input logic [63:0] v, input logic [7:0] sel,
                                     input logic en, input logic k);
        return ((ref_cats(v) & sel) != 0) && (!en || k);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [63:0] v, input logic [7:0] s, input logic en,
                         input logic k, input logic [3:0] rv);
        in_valid = 1'b1; in_value = v; in_sel = s;
        in_mask_en = en; in_kbit = k; in_resv = rv;
        if (rv == 4'hF) m_mask = {63'b0, ref_bit(v, s, en, k)};
        m_ill = (rv != 4'hF);
    endtask

    task automatic check_out(input string req);
        chk(out_valid == 1'b1, {req, " out_valid"}, {63'b0, out_valid}, 64'd1);
        chk(out_mask == m_mask, {req, " out_mask"}, out_mask, m_mask);
        chk(out_illegal == m_ill, {req, " out_illegal"}, {63'b0, out_illegal}, {63'b0, m_ill});
    endtask

    task automatic send(input logic [63:0] v, input logic [7:0] s, input logic en,
                        input logic k, input logic [3:0] rv, input string req);
        @(negedge clk);
        drive(v, s, en, k, rv);
        @(negedge clk);
        in_valid = 1'b0;
        check_out(req);
    endtask

    function automatic logic [63:0] rnd_value();
        logic [10:0] e;
        logic [51:0] f;
        case ($urandom_range(0, 3))
            0: e = 11'h000;
            1: e = 11'h7FF;
            default: e = 11'($urandom);
        endcase
        case ($urandom_range(0, 3))
            0: f = '0;
            1: f = {1'b1, 51'($urandom)};
            2: f = {1'b0, 19'($urandom), 32'($urandom)};
            default: f = 52'd1;
        endcase
        return {1'($urandom), e, f};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(out_valid == 0, "R10 out_valid", {63'b0, out_valid}, 0);
        chk(out_mask == 0, "R10 out_mask", out_mask, 0);
        chk(out_illegal == 0, "R10 out_illegal", {63'b0, out_illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1, "R9 ready when empty", {63'b0, in_ready}, 1);

        // R1 R2 directed categories, one select bit each
        send(64'h7FF8_0000_0000_0000, 8'h01, 0, 0, 4'hF, "R1 qnan");
        send(64'h7FF0_0000_0000_0001, 8'h80, 0, 0, 4'hF, "R1 snan");
        send(64'h7FF0_0000_0000_0001, 8'h01, 0, 0, 4'hF, "R1 snan not qnan");
        send(64'h0000_0000_0000_0000, 8'h02, 0, 0, 4'hF, "R1 +0");
        send(64'h8000_0000_0000_0000, 8'h04, 0, 0, 4'hF, "R1 -0");
        send(64'h8000_0000_0000_0000, 8'h40, 0, 0, 4'hF, "R1 -0 finite neg");
        send(64'h7FF0_0000_0000_0000, 8'h08, 0, 0, 4'hF, "R1 +inf");
        send(64'hFFF0_0000_0000_0000, 8'h10, 0, 0, 4'hF, "R1 -inf");
        send(64'hFFF0_0000_0000_0000, 8'h40, 0, 0, 4'hF, "R1 -inf not finite neg");
        send(64'h800F_FFFF_FFFF_FFFF, 8'h20, 0, 0, 4'hF, "R1 denormal");
        send(64'h3FF0_0000_0000_0000, 8'h7F, 0, 0, 4'hF, "R2 normal none");
        send(64'h3FF0_0000_0000_0000, 8'hFF, 0, 0, 4'hF, "R2 normal all");
        // R3 zero select
        send(64'h7FF8_0000_0000_0000, 8'h00, 0, 0, 4'hF, "R3 zero select");
        // R4 write mask
        send(64'h0000_0000_0000_0000, 8'h02, 1, 0, 4'hF, "R4 masked off");
        send(64'h0000_0000_0000_0000, 8'h02, 1, 1, 4'hF, "R4 mask on");
        // R6 illegal keeps previous mask (currently 1)
        send(64'h3FF0_0000_0000_0000, 8'h00, 0, 0, 4'h7, "R6 illegal");
        // R7 legal clears flag
        send(64'h3FF0_0000_0000_0000, 8'h00, 0, 0, 4'hF, "R7 legal");
        send(64'h8000_0000_0000_0001, 8'h20, 0, 0, 4'h0, "R6 illegal keep zero");

        // R8 stall: result held while out_ready low
        @(negedge clk);
        out_ready = 1'b0;
        drive(64'hFFF0_0000_0000_0000, 8'h10, 0, 0, 4'hF);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_out("R8 stall hold");
        chk(in_ready == 0, "R9 not ready when full", {63'b0, in_ready}, 0);
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 0, "R8 drain", {63'b0, out_valid}, 0);

        // back-to-back reload, then illegal right behind legal
        @(negedge clk);
        drive(64'h0000_0000_0000_0001, 8'h20, 0, 0, 4'hF);
        @(negedge clk);
        check_out("R8 reload first");
        drive(64'h7FF8_0000_0000_0000, 8'h01, 1, 1, 4'hF);
        @(negedge clk);
        check_out("R8 reload second");
        drive(64'h0000_0000_0000_0000, 8'h00, 0, 0, 4'hE);
        @(negedge clk);
        in_valid = 1'b0;
        check_out("R6 illegal after legal");

        // random traffic
        for (int i = 0; i < 300; i++) begin
            logic [3:0] rv;
            rv = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
            send(rnd_value(), 8'($urandom), 1'($urandom), 1'($urandom), rv,
                 "R2 random");
            chk(out_mask[63:1] == 0, "R5 upper bits", out_mask, m_mask);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule